// File: doc/BRIEF.md
# Serial Frame Shifter with Selectable Clock Phase

This block is the controller side of a two-wire serial link. A single start strobe moves one 9-bit frame out on the data line, most significant data bit first, while the block drives the clock line. During the same clocks it shifts the frame that the far end places on the data line into a receive shift register. Both lines are open-drain: each output is an enable that pulls the line low, and releasing it lets the line float high.

A clock-phase select changes three things: the clock level while idle, the point in the frame at which the transfer interrupt fires, and how many times the receive buffer is loaded. The select takes effect only when both mode enables are set; otherwise phase 0 applies. The data-line output can be delayed by a programmable number of count-source cycles, which moves data changes clear of the falling clock edge. Bus start and stop conditions, arbitration and clock stretching are handled elsewhere.

Top module: `i2c_phase_shifter`

## Requirements
- R1: Frame bits go out in this order: tx_word_i[7] down to tx_word_i[0], then tx_word_i[8]. For bit b, sda_oe_o is 1 (line pulled low) exactly when that bit is 0. The level holds for the low half and the high half of clock b, and the line is released at every other time.
- R2: Each clock half lasts H = half_div_i+1 count-source cycles (with the default prescale, every system clock is a count-source cycle). A frame starts with a low half, and scl_oe_o is 1 during low halves. Phase 0 gives 9 clock pulses and phase 1 gives 10; the tenth carries no data.
- R3: Before the first transfer after reset, the idle clock is released (scl_oe_o=0) under effective phase 0 and pulled low (scl_oe_o=1) under effective phase 1. After any transfer it stays low.
- R4: The effective phase is phase_sel_i AND i2c_en_a_i AND i2c_en_b_i. If either enable is 0, the block behaves exactly as phase 0.
- R5: tx_irq_o is a one-cycle pulse. Under phase 0 it comes with the rising edge of the ninth clock. Under phase 1 it comes with the falling edge of the tenth clock, in the first cycle after busy_o drops.
- R6: rx_wr_o pulses in each cycle in which rx_buf_o is loaded, and rx_buf_o changes at no other time. Phase 0 loads once, at the falling edge of the ninth clock. Phase 1 loads twice: at the rising edge and again at the falling edge of the ninth clock.
- R7: sda_in_i is sampled on each rising clock edge. The loaded buffer holds the first eight received bits in rx_buf_o[7:0], first bit in bit 7, and the ninth received bit in rx_buf_o[8].
- R8: Delay code sda_dly_i = 0 applies no delay. Codes 1 to 7 delay every change of sda_oe_o by code+1 count-source cycles, giving 2 to 8.
- R9: busy_o is 1 from the cycle after an accepted start through the last high half. It drops in the same cycle in which the clock makes its final fall.
- R10: A start strobe while busy_o=1 is ignored. The phase, the transmit word and the divider are captured at the start, so changes to them during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| tx_word_i | input | 9 | Frame to send; bit 8 is the ninth bit |
| half_div_i | input | DIV_W | Clock half-period minus one, in count-source cycles |
| phase_sel_i | input | 1 | Clock-phase select |
| i2c_en_a_i | input | 1 | First mode enable |
| i2c_en_b_i | input | 1 | Second mode enable |
| sda_dly_i | input | 3 | Data-output delay code |
| sda_in_i | input | 1 | Data-line level |
| scl_oe_o | output | 1 | Pull clock line low |
| sda_oe_o | output | 1 | Pull data line low |
| rx_buf_o | output | 9 | Receive buffer |
| rx_wr_o | output | 1 | Receive-buffer load pulse |
| tx_irq_o | output | 1 | Transfer interrupt pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
Cycles are counted from the clock edge that accepts the start, with t=0 as the cycle that follows it. The clock toggles every H cycles from t=0. The interrupt is due at t=17H under phase 0 and at t=20H under phase 1. Buffer loads fall at t=18H, plus t=17H under phase 1, and busy_o ends at 18H or 20H. The data output at t equals the undelayed level at t-d. The bench derives each of these times from arithmetic on t and compares every output in every cycle, at the falling system-clock edge, so each result is sampled in the exact cycle it is due.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
  localparam int FRAME_BITS = 9;
  localparam int DLY_CODE_W = 3;
  localparam int DLY_MAX    = 2 ** DLY_CODE_W;

  // Delay code to count-source cycles: 0 -> none, k -> k+1.
  function automatic logic [3:0] dly_cycles(input logic [DLY_CODE_W-1:0] code);
    return (code == '0) ? 4'd0 : ({1'b0, code} + 4'd1);
  endfunction

  // Transmit bit for clock index: data bits MSB first, then the ninth bit.
  function automatic logic frame_bit(input logic [FRAME_BITS-1:0] w, input logic [3:0] idx);
    return (idx < 4'd8) ? w[3'(4'd7 - idx)] : w[8];
  endfunction

  // Receive shift register (first bit at the top) to buffer layout.
  function automatic logic [FRAME_BITS-1:0] shift_to_buf(input logic [FRAME_BITS-1:0] s);
    return {s[0], s[8:1]};
  endfunction
endpackage

// File: rtl/i2cps_cs_gen.sv
module i2cps_cs_gen #(
  parameter int CS_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (CS_DIV > 1) ? $clog2(CS_DIV) : 1;
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == W'(CS_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cps_seq.sv
module i2cps_seq
  import i2cps_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic [DIV_W-1:0]      div,
  input  logic                  phase_eff,
  input  logic                  sda_in,
  output logic                  busy,
  output logic                  scl_oe,
  output logic                  sda_want,
  output logic [FRAME_BITS-1:0] rx_buf,
  output logic                  rx_wr,
  output logic                  tx_irq,
  output logic                  ev_rise,
  output logic                  ev_fall
);
  logic                  busy_q, hi_q, ph_q, park_q;
  logic [3:0]            idx_q;
  logic [DIV_W-1:0]      cnt_q, div_q;
  logic [FRAME_BITS-1:0] txw_q, rxs_q, rx_buf_q, rx_next;
  logic                  rx_wr_q, irq_q;
  logic                  half_end, ev_done, ninth_rise, ninth_fall, irq_ev, wr_ev, accept;
  logic [3:0]            last_idx;

  assign accept     = start & ~busy_q;
  assign half_end   = busy_q & tick & (cnt_q == div_q);
  assign ev_rise    = half_end & ~hi_q;
  assign ev_fall    = half_end & hi_q;
  assign last_idx   = ph_q ? 4'd9 : 4'd8;
  assign ev_done    = ev_fall & (idx_q == last_idx);
  assign ninth_rise = ev_rise & (idx_q == 4'd8);
  assign ninth_fall = ev_fall & (idx_q == 4'd8);
  assign irq_ev     = ph_q ? ev_done : ninth_rise;
  assign wr_ev      = ninth_fall | (ph_q & ninth_rise);
  assign rx_next    = ev_rise ? {rxs_q[FRAME_BITS-2:0], sda_in} : rxs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; hi_q <= 1'b0; ph_q <= 1'b0; park_q <= 1'b0;
      idx_q <= '0; cnt_q <= '0; div_q <= '0;
      txw_q <= '0; rxs_q <= '0; rx_buf_q <= '0;
      rx_wr_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      rx_wr_q <= wr_ev;
      irq_q   <= irq_ev;
      if (accept) begin
        busy_q <= 1'b1; hi_q <= 1'b0; idx_q <= '0; cnt_q <= '0;
        ph_q <= phase_eff; txw_q <= tx_word; div_q <= div;
      end else if (busy_q && tick) begin
        if (!half_end) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          if (ev_rise) begin
            hi_q  <= 1'b1;
            rxs_q <= rx_next;
          end else if (ev_done) begin
            busy_q <= 1'b0;
            hi_q   <= 1'b0;
            park_q <= 1'b1;
          end else begin
            hi_q  <= 1'b0;
            idx_q <= idx_q + 1'b1;
          end
        end
      end
      if (wr_ev) rx_buf_q <= shift_to_buf(rx_next);
    end
  end

  assign busy     = busy_q;
  assign scl_oe   = busy_q ? ~hi_q : (park_q | phase_eff);
  assign sda_want = busy_q & (idx_q < 4'd9) & ~frame_bit(txw_q, idx_q);
  assign rx_buf   = rx_buf_q;
  assign rx_wr    = rx_wr_q;
  assign tx_irq   = irq_q;
endmodule

// File: rtl/i2cps_sda_dly.sv
module i2cps_sda_dly
  import i2cps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [DLY_CODE_W-1:0] code,
  input  logic                  din,
  output logic                  dout
);
  logic [DLY_MAX:1] line_q;
  logic [3:0]       taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= '0;
    else if (tick) line_q <= {line_q[DLY_MAX-1:1], din};
  end

  assign taps = dly_cycles(code);
  assign dout = (taps == 4'd0) ? din : line_q[taps];
endmodule

// File: rtl/i2c_phase_shifter.sv
module i2c_phase_shifter
  import i2cps_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CS_DIV = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] tx_word_i,
  input  logic [DIV_W-1:0]      half_div_i,
  input  logic                  phase_sel_i,
  input  logic                  i2c_en_a_i,
  input  logic                  i2c_en_b_i,
  input  logic [DLY_CODE_W-1:0] sda_dly_i,
  input  logic                  sda_in_i,
  output logic                  scl_oe_o,
  output logic                  sda_oe_o,
  output logic [FRAME_BITS-1:0] rx_buf_o,
  output logic                  rx_wr_o,
  output logic                  tx_irq_o,
  output logic                  busy_o
);
  logic cs_tick, phase_eff, sda_want, ev_rise, ev_fall;

  assign phase_eff = phase_sel_i & i2c_en_a_i & i2c_en_b_i;

  i2cps_cs_gen #(.CS_DIV(CS_DIV)) u_cs (
    .clk(clk), .rst_n(rst_n), .tick(cs_tick)
  );

  i2cps_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(cs_tick), .start(start_i),
    .tx_word(tx_word_i), .div(half_div_i), .phase_eff(phase_eff),
    .sda_in(sda_in_i), .busy(busy_o), .scl_oe(scl_oe_o),
    .sda_want(sda_want), .rx_buf(rx_buf_o), .rx_wr(rx_wr_o),
    .tx_irq(tx_irq_o), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  i2cps_sda_dly u_dly (
    .clk(clk), .rst_n(rst_n), .tick(cs_tick), .code(sda_dly_i),
    .din(sda_want), .dout(sda_oe_o)
  );
endmodule

// File: rtl/i2c_phase_shifter_chk.sv
module i2c_phase_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       tx_irq,
  input logic       rx_wr,
  input logic [8:0] rx_buf,
  input logic [2:0] sda_dly,
  input logic       ev_rise,
  input logic       ev_fall
);
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_irq |=> !tx_irq);
  // R5
  irq_window_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_irq |-> (busy || $past(busy)));
  // R6
  buf_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_buf) |-> rx_wr);
  // R3
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> scl_oe);
  // R8
  nodly_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (sda_dly == 3'd0 && !busy) |-> !sda_oe);
  // R2
  scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_rise |=> !scl_oe);
  // R2
  scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_fall |=> scl_oe);
endmodule

bind i2c_phase_shifter i2c_phase_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .scl_oe(scl_oe_o), .sda_oe(sda_oe_o),
  .tx_irq(tx_irq_o), .rx_wr(rx_wr_o), .rx_buf(rx_buf_o), .sda_dly(sda_dly_i),
  .ev_rise(ev_rise), .ev_fall(ev_fall)
);

// File: tb/i2c_phase_shifter_test.sv
module i2c_phase_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] tx_word_i = '0;
  logic [7:0] half_div_i = '0;
  logic       phase_sel_i = 1'b0, i2c_en_a_i = 1'b0, i2c_en_b_i = 1'b0;
  logic [2:0] sda_dly_i = '0;
  logic       sda_in_i = 1'b1;
  logic       scl_oe_o, sda_oe_o, rx_wr_o, tx_irq_o, busy_o;
  logic [8:0] rx_buf_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [8:0] held_buf = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_phase_shifter uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
    .half_div_i(half_div_i), .phase_sel_i(phase_sel_i), .i2c_en_a_i(i2c_en_a_i),
    .i2c_en_b_i(i2c_en_b_i), .sda_dly_i(sda_dly_i), .sda_in_i(sda_in_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .rx_buf_o(rx_buf_o),
    .rx_wr_o(rx_wr_o), .tx_irq_o(tx_irq_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic bit fbit(input logic [8:0] w, input int b);
    if (b < 8) return w[7-b];
    return w[8];
  endfunction

  // Undelayed pull-low level at cycle t of a frame (R1).
  function automatic bit want_low(input int t, input int h_len, input logic [8:0] w);
    if (t < 0 || t >= 18*h_len) return 1'b0;
    return !fbit(w, (t / h_len) / 2);
  endfunction

  task automatic run_xfer(input logic [8:0] tx, input logic [8:0] slave, input int div,
                          input bit ph, input bit ea, input bit eb, input logic [2:0] dly,
                          input bit disturb);
    bit p;
    int h_len, halves, d, end_t, h;
    p = ph & ea & eb;
    h_len = div + 1;
    halves = p ? 20 : 18;
    d = (dly == 0) ? 0 : int'(dly) + 1;
    end_t = halves*h_len + d + 3;
    @(negedge clk);
    tx_word_i = tx; half_div_i = 8'(div); phase_sel_i = ph;
    i2c_en_a_i = ea; i2c_en_b_i = eb; sda_dly_i = dly; start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    for (int t = 0; t <= end_t; t++) begin
      bit exp_busy, exp_scl, exp_irq, exp_wr, exp_sda;
      string tg;
      @(negedge clk);
      h = t / h_len;
      if (h/2 < 9) sda_in_i = fbit(slave, h/2);
      else sda_in_i = 1'b1;
      if (disturb && t == 3) begin
        // R10: restart attempt and changed settings mid-frame
        start_i = 1'b1; tx_word_i = ~tx; phase_sel_i = ~ph; half_div_i = 8'(div + 2);
      end
      if (disturb && t == 4) begin
        start_i = 1'b0; tx_word_i = tx; phase_sel_i = ph; half_div_i = 8'(div);
      end
      exp_busy = (t < halves*h_len);
      exp_scl  = exp_busy ? (h % 2 == 0) : 1'b1;
      exp_irq  = p ? (t == 20*h_len) : (t == 17*h_len);
      exp_wr   = p ? (t == 17*h_len || t == 18*h_len) : (t == 18*h_len);
      exp_sda  = want_low(t - d, h_len, tx);
      if (exp_wr) held_buf = slave;
      tg = (disturb && t > 3) ? "R10" : "";
      chk(busy_o == exp_busy, (tg != "") ? tg : "R9", int'(busy_o), int'(exp_busy));
      chk(scl_oe_o == exp_scl, (tg != "") ? tg : ((ph && !p) ? "R4" : "R2"), int'(scl_oe_o), int'(exp_scl));
      chk(sda_oe_o == exp_sda, (tg != "") ? tg : ((d > 0) ? "R8" : "R1"), int'(sda_oe_o), int'(exp_sda));
      chk(tx_irq_o == exp_irq, "R5", int'(tx_irq_o), int'(exp_irq));
      chk(rx_wr_o == exp_wr, "R6", int'(rx_wr_o), int'(exp_wr));
      chk(rx_buf_o == held_buf, "R7", int'(rx_buf_o), int'(held_buf));
    end
    // R3: clock stays low once the frame is over
    chk(scl_oe_o == 1'b1, "R3", int'(scl_oe_o), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    phase_sel_i = 1'b1; i2c_en_a_i = 1'b1; i2c_en_b_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
    chk(rx_buf_o == 9'h000, "R6", int'(rx_buf_o), 0);
    chk(sda_oe_o == 1'b0, "R1", int'(sda_oe_o), 0);
    chk(tx_irq_o == 1'b0 && rx_wr_o == 1'b0, "R5", int'({tx_irq_o, rx_wr_o}), 0);
    // R4: one enable off -> phase 0 idle (released)
    chk(scl_oe_o == 1'b0, "R4", int'(scl_oe_o), 0);
    @(negedge clk) i2c_en_b_i = 1'b1;
    #1 chk(scl_oe_o == 1'b1, "R3", int'(scl_oe_o), 1);
    @(negedge clk) i2c_en_b_i = 1'b0;
    #1 chk(scl_oe_o == 1'b0, "R3", int'(scl_oe_o), 0);

    run_xfer(9'h0A5, 9'h13C, 1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0);
    run_xfer(9'h15A, 9'h0C3, 2, 1'b1, 1'b1, 1'b1, 3'd3, 1'b1);
    run_xfer(9'h1F0, 9'h055, 0, 1'b1, 1'b0, 1'b1, 3'd7, 1'b0);
    run_xfer(9'h00F, 9'h1AA, 3, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0);
    run_xfer(9'h133, 9'h0FF, 0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule